// File: doc/BRIEF.md
# Network Board Control Register and Parity Capture

This block is the host-facing control and status logic of a shared-memory network interface board. The host reaches it through a word-addressed 16-bit register window. It contains three registers. The status word holds the controller reset, loopback release, channel attention and the two interrupt enables, and it reports the board straps and the pending flags. The parity control word reports a captured memory parity error and acknowledges it. The low-address word holds bits [15:0] of the faulting address.

Parity errors arrive from the memory side as a single-cycle strobe, together with a 20-bit address, the requesting side and the byte lane. The first error is held until software acknowledges it. The level interrupt from the network controller is registered into the status word. The controller interrupt and the parity error are then combined into one host interrupt line, each under its own enable. Reads are combinational from the address. Writes take effect at the clock edge where `host_wr_i` is high. All control and status pins are plain levels, and the block applies no back-pressure: every access completes in one cycle.

Top module: `nic_board_csr`

## Requirements
- R1: After reset, the status word reads only the strap bits (bit 4 = `ram_256k_i`, bits [3:0] = `board_haddr_i`). The parity control word and the low-address word read 0, and `ctl_reset_o`, `ctl_attn_o`, `ctl_on_air_o`, `p2_en_o` and `host_irq_o` are all 0.
- R2: A write to the status word (word 1056) sets `ctl_reset_o` to written bit 15 from the next cycle. The level holds until the next status write.
- R3: Status bit 13 drives `ctl_attn_o` as a registered level. A write that sets the bit, followed by a later write that clears it, produces exactly one attention pulse.
- R4: Status bit 14 drives `ctl_on_air_o`, bit 5 drives `p2_en_o`, and bits 12 (controller interrupt enable) and 11 (parity interrupt enable) are stored. All four read back as written.
- R5: Status bits 9, 8, 4 and [3:0] are read-only, and writes to them have no effect. Bits 10, 7 and 6 read 0.
- R6: A parity strobe with no error pending sets status bit 9 in the next cycle. It also captures, in the parity control word, address bits [19:16] in bits [3:0], the source in bit 7 and the lane in bit 6. Address bits [15:0] go to the low-address word (word 1059).
- R7: While an error is pending, further parity strobes are ignored and the captured fields stay frozen.
- R8: Writing the parity control word (word 1058) with bit 8 set clears the pending error. Writing it with bit 8 clear does not. Bit 8 always reads 0. A strobe in the same cycle as an acknowledge is captured as a new pending error.
- R9: The controller interrupt input shows in status bit 8 one cycle after it changes.
- R10: `host_irq_o` is (status bit 8 AND bit 12) OR (status bit 9 AND bit 11).
- R11: Only words 1056, 1058 and 1059 decode. The filler word 1057 and all other addresses read 0, and writes to them have no effect. The low-address word is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_i | input | 11 | Host word address |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data for `host_addr_i` |
| board_haddr_i | input | 4 | Board address strap, bits 17-20 |
| ram_256k_i | input | 1 | RAM size strap |
| ctl_irq_i | input | 1 | Network controller interrupt level |
| par_err_i | input | 1 | Parity error strobe |
| par_err_addr_i | input | 20 | Faulting memory address |
| par_err_src_i | input | 1 | Side that made the faulting access |
| par_err_lane_i | input | 1 | Byte lane that failed |
| ctl_reset_o | output | 1 | Controller reset level |
| ctl_attn_o | output | 1 | Controller channel attention |
| ctl_on_air_o | output | 1 | Release from loopback |
| p2_en_o | output | 1 | Secondary memory bus enable |
| host_irq_o | output | 1 | Combined host interrupt |

## Verification
The assertions assume that the parity strobe, its address, source and lane are valid together in one cycle. They also assume that `host_wr_i` and `host_addr_i` are steady around the rising edge. The bench drives all of these inputs on the falling edge and holds each strobe for exactly one cycle, so every sampled edge sees settled inputs. The bench also tests an acknowledge and a new strobe landing on the same edge, because capture priority is decided at that edge.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  // status word bit positions (decoded by host software)
  localparam int ST_RESET = 15;
  localparam int ST_ONAIR = 14;
  localparam int ST_ATTN  = 13;
  localparam int ST_IEN   = 12;
  localparam int ST_PIEN  = 11;
  localparam int ST_PERR  = 9;
  localparam int ST_CINT  = 8;
  localparam int ST_P2EN  = 5;
  localparam int ST_RAMSZ = 4;
  // parity control word bit positions
  localparam int PC_ACK   = 8;
  localparam int PC_SRC   = 7;
  localparam int PC_LANE  = 6;

  typedef struct packed {
    logic rst;
    logic onair;
    logic attn;
    logic ien;
    logic pien;
    logic p2en;
  } ctrl_t;
endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.rst   <= wdata_i[ST_RESET];
      ctrl_q.onair <= wdata_i[ST_ONAIR];
      ctrl_q.attn  <= wdata_i[ST_ATTN];
      ctrl_q.ien   <= wdata_i[ST_IEN];
      ctrl_q.pien  <= wdata_i[ST_PIEN];
      ctrl_q.p2en  <= wdata_i[ST_P2EN];
    end
  end

  assign ctrl_o = ctrl_q;

  AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ctrl_o.rst == $past(wdata_i[ST_RESET])); // R2
  AST_ATTN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ctrl_o.attn == $past(wdata_i[ST_ATTN])); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o)); // R4
endmodule

// File: rtl/nic_csr_parity.sv
module nic_csr_parity #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              err_src_i,
  input  logic              err_lane_i,
  input  logic              ack_i,
  output logic              pending_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic              cap_src_o,
  output logic              cap_lane_o
);
  logic              pending_q;
  logic [ADDR_W-1:0] addr_q;
  logic              src_q;
  logic              lane_q;
  logic              take;

  // an acknowledge on the same edge frees the slot for a fresh error
  assign take = err_i && (!pending_q || ack_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      addr_q    <= '0;
      src_q     <= 1'b0;
      lane_q    <= 1'b0;
    end else begin
      if (take) begin
        pending_q <= 1'b1;
        addr_q    <= err_addr_i;
        src_q     <= err_src_i;
        lane_q    <= err_lane_i;
      end else if (ack_i) begin
        pending_q <= 1'b0;
      end
    end
  end

  assign pending_o  = pending_q;
  assign cap_addr_o = addr_q;
  assign cap_src_o  = src_q;
  assign cap_lane_o = lane_q;

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !pending_o) |=> pending_o && cap_addr_o == $past(err_addr_i)); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !ack_i) |=> pending_o && $stable(cap_addr_o) && $stable(cap_src_o)
      && $stable(cap_lane_o)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !err_i) |=> !pending_o); // R8
  AST_ACK_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && err_i) |=> pending_o && cap_addr_o == $past(err_addr_i)); // R8
endmodule

// File: rtl/nic_csr_irq.sv
module nic_csr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_irq_i,
  input  logic ien_i,
  input  logic pien_i,
  input  logic perr_i,
  output logic cint_o,
  output logic host_irq_o
);
  logic cint_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cint_q <= 1'b0;
    else        cint_q <= ctl_irq_i;
  end

  assign cint_o     = cint_q;
  assign host_irq_o = (cint_q & ien_i) | (perr_i & pien_i);

  AST_CINT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cint_o == $past(ctl_irq_i)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_i && !pien_i) |-> !host_irq_o); // R10
  AST_IRQ_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_i && pien_i) |-> host_irq_o); // R10
endmodule

// File: rtl/nic_board_csr.sv
module nic_board_csr
  import nic_csr_pkg::*;
#(
  parameter int MAP_WORDS  = 1024,
  parameter int ID_WORDS   = 32,
  parameter int ADDR_W     = 11,
  parameter int PAR_ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     host_addr_i,
  input  logic                  host_wr_i,
  input  logic [15:0]           host_wdata_i,
  output logic [15:0]           host_rdata_o,
  input  logic [3:0]            board_haddr_i,
  input  logic                  ram_256k_i,
  input  logic                  ctl_irq_i,
  input  logic                  par_err_i,
  input  logic [PAR_ADDR_W-1:0] par_err_addr_i,
  input  logic                  par_err_src_i,
  input  logic                  par_err_lane_i,
  output logic                  ctl_reset_o,
  output logic                  ctl_attn_o,
  output logic                  ctl_on_air_o,
  output logic                  p2_en_o,
  output logic                  host_irq_o
);
  localparam int DATA_W    = 16;
  localparam int HI_W      = PAR_ADDR_W - DATA_W;
  localparam int OFS_STAT  = MAP_WORDS + ID_WORDS;
  localparam int OFS_FILL  = OFS_STAT + 1;
  localparam int OFS_PCTL  = OFS_STAT + 2;
  localparam int OFS_PLOW  = OFS_STAT + 3;

  logic sel_stat, sel_pctl, sel_plow;
  assign sel_stat = host_addr_i == ADDR_W'(OFS_STAT);
  assign sel_pctl = host_addr_i == ADDR_W'(OFS_PCTL);
  assign sel_plow = host_addr_i == ADDR_W'(OFS_PLOW);

  ctrl_t                 ctrl;
  logic                  perr;
  logic [PAR_ADDR_W-1:0] cap_addr;
  logic                  cap_src, cap_lane;
  logic                  cint;
  logic                  ack;

  assign ack = host_wr_i && sel_pctl && host_wdata_i[PC_ACK];

  nic_csr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (host_wr_i && sel_stat),
    .wdata_i (host_wdata_i),
    .ctrl_o  (ctrl)
  );

  nic_csr_parity #(.ADDR_W(PAR_ADDR_W)) u_par (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_i      (par_err_i),
    .err_addr_i (par_err_addr_i),
    .err_src_i  (par_err_src_i),
    .err_lane_i (par_err_lane_i),
    .ack_i      (ack),
    .pending_o  (perr),
    .cap_addr_o (cap_addr),
    .cap_src_o  (cap_src),
    .cap_lane_o (cap_lane)
  );

  nic_csr_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_irq_i  (ctl_irq_i),
    .ien_i      (ctrl.ien),
    .pien_i     (ctrl.pien),
    .perr_i     (perr),
    .cint_o     (cint),
    .host_irq_o (host_irq_o)
  );

  assign ctl_reset_o  = ctrl.rst;
  assign ctl_attn_o   = ctrl.attn;
  assign ctl_on_air_o = ctrl.onair;
  assign p2_en_o      = ctrl.p2en;

  logic [DATA_W-1:0] stat_word, pctl_word;

  always_comb begin
    stat_word           = '0;
    stat_word[ST_RESET] = ctrl.rst;
    stat_word[ST_ONAIR] = ctrl.onair;
    stat_word[ST_ATTN]  = ctrl.attn;
    stat_word[ST_IEN]   = ctrl.ien;
    stat_word[ST_PIEN]  = ctrl.pien;
    stat_word[ST_PERR]  = perr;
    stat_word[ST_CINT]  = cint;
    stat_word[ST_P2EN]  = ctrl.p2en;
    stat_word[ST_RAMSZ] = ram_256k_i;
    stat_word[3:0]      = board_haddr_i;
  end

  always_comb begin
    pctl_word          = '0;
    pctl_word[PC_SRC]  = cap_src;
    pctl_word[PC_LANE] = cap_lane;
    pctl_word[HI_W-1:0] = cap_addr[PAR_ADDR_W-1:DATA_W];
  end

  always_comb begin
    if (sel_stat)      host_rdata_o = stat_word;
    else if (sel_pctl) host_rdata_o = pctl_word;
    else if (sel_plow) host_rdata_o = cap_addr[DATA_W-1:0];
    else               host_rdata_o = '0;
  end

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && !sel_stat) |=> $stable(ctl_reset_o) && $stable(ctl_attn_o)
      && $stable(ctl_on_air_o) && $stable(p2_en_o)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr_i == ADDR_W'(OFS_FILL) |-> host_rdata_o == '0); // R11
endmodule

// File: tb/nic_board_csr_tb.sv
module nic_board_csr_tb;
  localparam logic [10:0] A_STAT = 11'd1056;
  localparam logic [10:0] A_FILL = 11'd1057;
  localparam logic [10:0] A_PCTL = 11'd1058;
  localparam logic [10:0] A_PLOW = 11'd1059;
  localparam int NV = 7;
  // {status write data, expected status readback}; straps give 0x001A
  localparam logic [31:0] VEC [NV] = '{
    {16'hFFFF, 16'hF83A},
    {16'h0000, 16'h001A},
    {16'h4020, 16'h403A},
    {16'h0B1F, 16'h081A},
    {16'h1000, 16'h101A},
    {16'h8000, 16'h801A},
    {16'h0000, 16'h001A}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] host_addr = '0;
  logic        host_wr = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ctl_irq = 0;
  logic        par_err = 0;
  logic [19:0] par_addr = '0;
  logic        par_src = 0;
  logic        par_lane = 0;
  logic        ctl_reset, ctl_attn, ctl_on_air, p2_en, host_irq;

  int checks = 0;
  int errors = 0;
  int attn_rises = 0;
  logic attn_prev = 0;

  always #4 clk = ~clk;

  nic_board_csr u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr), .host_wr_i(host_wr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .board_haddr_i(4'hA), .ram_256k_i(1'b1), .ctl_irq_i(ctl_irq),
    .par_err_i(par_err), .par_err_addr_i(par_addr), .par_err_src_i(par_src),
    .par_err_lane_i(par_lane), .ctl_reset_o(ctl_reset), .ctl_attn_o(ctl_attn),
    .ctl_on_air_o(ctl_on_air), .p2_en_o(p2_en), .host_irq_o(host_irq)
  );

  always @(negedge clk) begin
    if (ctl_attn && !attn_prev) attn_rises++;
    attn_prev <= ctl_attn;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic strobe(input logic [19:0] a, input logic s, input logic l);
    @(negedge clk);
    par_err = 1; par_addr = a; par_src = s; par_lane = l;
    @(negedge clk);
    par_err = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 16'h001A);
    rd(A_PCTL, d); chk("R1 pctl", d, 16'h0000);
    rd(A_PLOW, d); chk("R1 plow", d, 16'h0000);
    chk("R1 outputs", {ctl_reset, ctl_attn, ctl_on_air, p2_en, host_irq}, 5'b0);

    // R2 R4 R5 status table
    for (int i = 0; i < NV; i++) begin
      wr(A_STAT, VEC[i][31:16]);
      rd(A_STAT, d);
      chk("R4 R5 status readback", d, VEC[i][15:0]);
      chk("R2 reset level", ctl_reset, VEC[i][15]);
      chk("R4 on-air/p2", {ctl_on_air, p2_en}, {VEC[i][14], VEC[i][5]});
      chk("R3 attn level", ctl_attn, VEC[i][13]);
    end

    // R3 set then clear gives one pulse
    attn_rises = 0;
    wr(A_STAT, 16'h2000);
    repeat (2) @(negedge clk);
    wr(A_STAT, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R3 pulse count", attn_rises, 1);
    chk("R3 attn low after clear", ctl_attn, 0);

    // R6 first capture, parity interrupt enabled
    wr(A_STAT, 16'h0800);
    strobe(20'h51234, 1'b1, 1'b0);
    rd(A_STAT, d); chk("R6 perr flag", d, 16'h0A1A);
    rd(A_PCTL, d); chk("R6 pctl fields", d, 16'h0085);
    rd(A_PLOW, d); chk("R6 low addr", d, 16'h1234);
    chk("R10 parity irq", host_irq, 1);

    // R7 second error ignored
    strobe(20'hCBEEF, 1'b0, 1'b1);
    rd(A_PCTL, d); chk("R7 pctl frozen", d, 16'h0085);
    rd(A_PLOW, d); chk("R7 low frozen", d, 16'h1234);

    // R8 write without ack keeps error, with ack clears
    wr(A_PCTL, 16'h00FF);
    rd(A_STAT, d); chk("R8 no-ack keeps", d[9], 1);
    wr(A_PCTL, 16'h0100);
    rd(A_STAT, d); chk("R8 ack clears", d, 16'h081A);
    chk("R10 irq drops", host_irq, 0);
    rd(A_PCTL, d); chk("R8 ack reads 0", d[8], 0);

    // R8 ack and new error on the same edge
    strobe(20'h30001, 1'b0, 1'b1);
    @(negedge clk);
    host_addr = A_PCTL; host_wdata = 16'h0100; host_wr = 1;
    par_err = 1; par_addr = 20'h9ABCD; par_src = 1; par_lane = 1;
    @(negedge clk);
    host_wr = 0; par_err = 0;
    rd(A_STAT, d); chk("R8 recapture pending", d[9], 1);
    rd(A_PCTL, d); chk("R8 recapture pctl", d, 16'h00C9);
    rd(A_PLOW, d); chk("R8 recapture low", d, 16'hABCD);
    wr(A_PCTL, 16'h0100);

    // R9 R10 controller interrupt
    wr(A_STAT, 16'h0000);
    @(negedge clk);
    ctl_irq = 1;
    host_addr = A_STAT;
    #1 chk("R9 not yet", host_rdata[8], 0);
    @(negedge clk);
    chk("R9 flag after one cycle", host_rdata, 16'h011A);
    chk("R10 masked", host_irq, 0);
    wr(A_STAT, 16'h1000);
    chk("R10 enabled", host_irq, 1);
    @(negedge clk);
    ctl_irq = 0;
    @(negedge clk);
    chk("R10 source gone", host_irq, 0);

    // R11 decode
    wr(A_FILL, 16'hFFFF);
    wr(11'd0, 16'hFFFF);
    wr(11'd1040, 16'hFFFF);
    wr(A_PLOW, 16'hFFFF);
    rd(A_STAT, d); chk("R11 status untouched", d, 16'h101A);
    rd(A_FILL, d); chk("R11 filler reads 0", d, 16'h0000);
    rd(11'd1040, d); chk("R11 id area reads 0", d, 16'h0000);
    rd(A_PLOW, d); chk("R11 low read-only", d, 16'hABCD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule